// File: doc/BRIEF.md
# Programmable Glitch Filter with Edge Interrupt

This block cleans up one slow external input, such as an interrupt line or the output of an infrared receiver, before the core sees it. A two-flop synchronizer first brings the pin into the clock domain. The synchronized level is then sampled on a tick that comes from the instruction-cycle enable. The tick rate is set by a 2-bit rate select: one sample per enabled cycle, one per 32, or one per 128. A new level is accepted only after two successive samples agree on it and both differ from the current filtered level.

The filtered level is a block output, so it can also drive the count input of a timer. The same level feeds an edge detector. This detector raises a single-clock interrupt pulse on rising edges only, falling edges only, or both, as the edge select chooses. The filtered level is not forced to a reset value. It starts from the pin level once the synchronizer has filled, so leaving reset never produces a spurious pulse.

Top module: `nf_edge_filter`

## Requirements
- R1: While `rst_n` is low, `irq_pulse` is 0. Within 3 clock edges after reset is released, `level_out` takes the pin level that was held through reset. This start-up step raises no `irq_pulse`.
- R2: With `rate_sel` = 0 (one sample per enabled cycle), a pin level that lasts 1 enabled cycle is ignored. A level that lasts 2 enabled cycles is accepted.
- R3: With `rate_sel` = 1 (one sample per 32 enabled cycles), a level that lasts 31 enabled cycles or fewer is ignored. A level that lasts 64 or more is accepted.
- R4: With `rate_sel` = 2 or 3 (one sample per 128 enabled cycles), a level that lasts 127 enabled cycles or fewer is ignored. A level that lasts 256 or more is accepted.
- R5: With `rate_sel` = 0 and `cyc_en` held high, a pin change set up before clock edge 1 appears on `level_out` right after edge 4, and not after edge 3.
- R6: While `cyc_en` is low, no sample is taken. `level_out` holds and no pulse is raised, whatever the pin does.
- R7: A change of `rate_sel` restarts the sample count. Count the enabled edges that follow the first edge that sees the new value. Samples fall on the Nth, 2Nth, and so on, of those edges, where N is 32 or 128.
- R8: `edge_sel` encodes the edge mode. 0 pulses on rising filtered edges only. 1 pulses on falling filtered edges only. 2 and 3 pulse on both.
- R9: Each qualifying filtered edge gives exactly one `irq_pulse` cycle. That cycle is the first one in which `level_out` shows the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; advances sampling |
| pin_raw | input | 1 | Unsynchronized input pin |
| rate_sel | input | 2 | Sample rate: 0 every cycle, 1 every 32, 2/3 every 128 |
| edge_sel | input | 2 | Edge mode: 0 rise, 1 fall, 2/3 both |
| level_out | output | 1 | Filtered level, also usable as timer event input |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong tick counter shows up at the ports as a shifted acceptance threshold. It is seen the first time a pulse near 32 or 128 cycles is let through or dropped, and as a wrong exact switch cycle right after a rate change. An extra or missing synchronizer or qualifier stage moves the `level_out` transition off edge 4 in the fastest mode, which is visible within five cycles. A faulty start-up or edge-mode decode appears as an unexpected pulse count after reset or after a single clean pulse.

// File: rtl/nf_pkg.sv
package nf_pkg;
   typedef enum logic [1:0] {
      RATE_EVERY = 2'd0,
      RATE_MID   = 2'd1,
      RATE_SLOW  = 2'd2,
      RATE_SLOW2 = 2'd3
   } rate_e;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'd0,
      EDGE_FALL  = 2'd1,
      EDGE_BOTH  = 2'd2,
      EDGE_BOTH2 = 2'd3
   } edge_e;
endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nf_sample_tick.sv
module nf_sample_tick
   import nf_pkg::*;
#(
   parameter int DIV_MID  = 32,
   parameter int DIV_SLOW = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_en,
   input  logic [1:0] rate_sel,
   output logic       tick
);
   localparam int CNT_W = $clog2(DIV_SLOW);
   localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(DIV_MID - 1);
   localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW - 1);

   if (DIV_MID < 2) begin : g_bad_mid
      $error("nf_sample_tick: DIV_MID must be at least 2");
   end
   if (DIV_SLOW < DIV_MID) begin : g_bad_slow
      $error("nf_sample_tick: DIV_SLOW must not be below DIV_MID");
   end

   logic [CNT_W-1:0] cnt;
   logic [1:0]       sel_q;
   logic             sel_chg;
   logic             at_lim;
   logic             every;
   logic [CNT_W-1:0] lim;

   always_comb begin
      every = 1'b0;
      lim   = LIM_SLOW;
      case (rate_e'(rate_sel))
         RATE_EVERY: every = 1'b1;
         RATE_MID:   lim   = LIM_MID;
         default:    lim   = LIM_SLOW;
      endcase
   end

   assign sel_chg = (sel_q != rate_sel);
   assign at_lim  = (cnt == lim);
   assign tick    = cyc_en && !sel_chg && (every || at_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= '0;
      end else begin
         sel_q <= rate_sel;
         if (sel_chg || every)  cnt <= '0;
         else if (cyc_en)       cnt <= at_lim ? '0 : cnt + 1'b1;
      end
   end

   // R3 / R4: in a divided mode two ticks never fall on adjacent cycles
   a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rate_sel != 2'd0) |=> !tick);
endmodule

// File: rtl/nf_qualifier.sv
module nf_qualifier #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic tick,
   output logic level,
   output logic ready
);
   localparam int IW = $clog2(SYNC_STAGES + 1);

   logic [IW-1:0] init_cnt;
   logic          smp_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_cnt <= '0;
         ready    <= 1'b0;
         level    <= 1'b0;
         smp_prev <= 1'b0;
      end else if (!ready) begin
         level    <= pin_s;
         smp_prev <= pin_s;
         init_cnt <= init_cnt + 1'b1;
         if (init_cnt == IW'(SYNC_STAGES)) ready <= 1'b1;
      end else if (tick) begin
         smp_prev <= pin_s;
         if (pin_s == smp_prev && pin_s != level) level <= pin_s;
      end
   end

   // R2: once running, the filtered level moves only on a sample tick
   a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && level != $past(level)) |-> $past(tick));
endmodule

// File: rtl/nf_edge_det.sv
module nf_edge_det
   import nf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready,
   input  logic       level,
   input  logic [1:0] edge_sel,
   output logic       irq
);
   logic lvl_q;
   logic en_q;
   logic rise;
   logic fall;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         lvl_q <= level;
         en_q  <= ready;
      end
   end

   assign rise = level & ~lvl_q;
   assign fall = ~level & lvl_q;

   always_comb begin
      case (edge_e'(edge_sel))
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         default:   hit = rise | fall;
      endcase
   end

   assign irq = en_q & hit;

   // R9: the pulse never lasts two cycles
   a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R8: rising mode pulses only with a high level, falling only with low
   a_r8_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && edge_sel == 2'd0) |-> level);
   a_r8_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && edge_sel == 2'd1) |-> !level);
endmodule

// File: rtl/nf_edge_filter.sv
module nf_edge_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DIV_MID     = 32,
   parameter int DIV_SLOW    = 128
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_en,
   input  logic       pin_raw,
   input  logic [1:0] rate_sel,
   input  logic [1:0] edge_sel,
   output logic       level_out,
   output logic       irq_pulse
);
   logic pin_s;
   logic tick;
   logic ready;

   nf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_s)
   );

   nf_sample_tick #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_en   (cyc_en),
      .rate_sel (rate_sel),
      .tick     (tick)
   );

   nf_qualifier #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pin_s),
      .tick  (tick),
      .level (level_out),
      .ready (ready)
   );

   nf_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (ready),
      .level    (level_out),
      .edge_sel (edge_sel),
      .irq      (irq_pulse)
   );

   // R9: a pulse always coincides with a fresh change of the filtered level
   a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (level_out != $past(level_out)));
   // R6: with no cycle enable the filtered level is frozen once running
   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ready) && !$past(cyc_en)) |-> $stable(level_out));
endmodule

// File: tb/nf_edge_filter_tb.sv
module nf_edge_filter_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cyc_en;
   logic       pin_raw;
   logic [1:0] rate_sel;
   logic [1:0] edge_sel;
   logic       level_out;
   logic       irq_pulse;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   nf_edge_filter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_en    (cyc_en),
      .pin_raw   (pin_raw),
      .rate_sel  (rate_sel),
      .edge_sel  (edge_sel),
      .level_out (level_out),
      .irq_pulse (irq_pulse)
   );

   always @(negedge clk) if (irq_pulse) irq_cnt <= irq_cnt + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // high pulse of w enabled cycles, then settle; returns pulses seen
   task automatic pulse(input int w, input int settle, output int d);
      int base;
      base = irq_cnt;
      @(negedge clk) pin_raw = 1'b1;
      repeat (w) @(negedge clk);
      pin_raw = 1'b0;
      repeat (settle) @(negedge clk);
      #1;
      d = irq_cnt - base;
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 120000);
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
   end

   initial begin
      int d;
      int base;
      rst_n = 1'b0; cyc_en = 1'b1; pin_raw = 1'b1;
      rate_sel = 2'd0; edge_sel = 2'd2;
      repeat (5) @(negedge clk);
      check("R1 irq in reset", int'(irq_pulse), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R1 start level", int'(level_out), 1);
      check("R1 no start pulse", irq_cnt, 0);

      // falling edge in both mode
      pin_raw = 1'b0;
      repeat (10) @(negedge clk);
      check("R8 both falling count", irq_cnt, 1);
      check("R8 level low", int'(level_out), 0);

      // R5 exact latency
      base = irq_cnt;
      @(negedge clk) pin_raw = 1'b1;
      repeat (3) @(posedge clk);
      #1 check("R5 not after edge 3", int'(level_out), 0);
      @(posedge clk);
      #1 check("R5 after edge 4", int'(level_out), 1);
      check("R9 pulse with new level", int'(irq_pulse), 1);
      @(posedge clk);
      #1 check("R9 pulse one cycle", int'(irq_pulse), 0);
      @(negedge clk) pin_raw = 1'b0;
      repeat (10) @(negedge clk);
      #1 check("R9 one count per edge", irq_cnt - base, 2);

      // R2 fastest mode
      pulse(1, 10, d);
      check("R2 width 1 ignored", d, 0);
      pulse(2, 10, d);
      check("R2 width 2 accepted", d, 2);
      pulse(3, 10, d);
      check("R2 width 3 accepted", d, 2);

      // R3 mid mode sweep
      rate_sel = 2'd1;
      repeat (120) @(negedge clk);
      for (int w = 1; w <= 31; w++) begin
         pulse(w, 3 * 32 + 8, d);
         check($sformatf("R3 width %0d ignored", w), d, 0);
      end
      for (int w = 64; w <= 70; w++) begin
         pulse(w, 3 * 32 + 8, d);
         check($sformatf("R3 width %0d accepted", w), d, 2);
      end

      // R4 slow modes
      for (int s = 2; s <= 3; s++) begin
         rate_sel = 2'(s);
         repeat (400) @(negedge clk);
         pulse(1, 3 * 128 + 8, d);
         check($sformatf("R4 sel %0d width 1 ignored", s), d, 0);
         pulse(127, 3 * 128 + 8, d);
         check($sformatf("R4 sel %0d width 127 ignored", s), d, 0);
         pulse(256, 3 * 128 + 8, d);
         check($sformatf("R4 sel %0d width 256 accepted", s), d, 2);
         pulse(300, 3 * 128 + 8, d);
         check($sformatf("R4 sel %0d width 300 accepted", s), d, 2);
      end

      // R6 no sampling without cycle enable
      rate_sel = 2'd0;
      repeat (20) @(negedge clk);
      cyc_en = 1'b0;
      base = irq_cnt;
      pin_raw = 1'b1;
      repeat (50) @(negedge clk);
      #1 check("R6 level held", int'(level_out), 0);
      pin_raw = 1'b0;
      repeat (10) @(negedge clk);
      #1 check("R6 no pulse", irq_cnt - base, 0);
      cyc_en = 1'b1;
      repeat (10) @(negedge clk);

      // R7 restart on rate change: switch at same negedge as pin change
      @(negedge clk);
      rate_sel = 2'd1;
      pin_raw = 1'b1;
      repeat (64) @(posedge clk);
      #1 check("R7 before second sample", int'(level_out), 0);
      @(posedge clk);
      #1 check("R7 at second sample", int'(level_out), 1);
      @(negedge clk) pin_raw = 1'b0;
      rate_sel = 2'd0;
      repeat (120) @(negedge clk);

      // R8 edge modes
      for (int m = 0; m <= 3; m++) begin
         edge_sel = 2'(m);
         pulse(10, 12, d);
         check($sformatf("R8 mode %0d count", m), d, (m < 2) ? 1 : 2);
      end

      summary();
   end
endmodule